// File: doc/BRIEF.md
# Read-Unlocked Aliased Configuration Register

This block holds one byte of configuration and status inside a paged register file. Its address, offset 0x0B on page 0, is shared with the high byte of a byte-count register. A host read of that address returns the configuration and status byte and also arms a one-shot unlock. The next access, if it is a write to the same address, goes into the configuration register. Any write to that address that does not directly follow such a read is steered to the byte-count register instead. The block flags this with a one-cycle write strobe for the register file.

The configuration byte selects the physical medium. The block decodes that choice onto a coax-enable output. In automatic mode the output follows a detected-media input from the transceiver side. One field chooses the point at which the bus-ready hold-off begins: after the command strobe, or after address latch enable rises. That choice is driven out as a control level. The byte also reports link status. It keeps a sticky bus-error flag, which the cycle monitor sets and which clears when the byte is read.

Top module: `cfgalias_reg`

## Requirements
- R1: After synchronous reset, the media field is 00, the ready-mode bit is 0 and the bus-error flag is 0. As a result, coax_en and ready_after_ale are 0 and the unlock is cleared.
- R2: While bus_rd is high with bus_page = 0 and bus_addr = 0x0B, cfg_rdata is {2'b00, bus-error, ready-mode, 1'b0, link_ok, media[1:0]}, with media in bits 1:0. In every other cycle, cfg_rdata is 0.
- R3: A write to page 0, offset 0x0B, whose previous access was a read of page 0, offset 0x0B, loads media from wdata[1:0] and ready-mode from wdata[4]. It does not pulse bcnt_hi_wr.
- R4: A write to page 0, offset 0x0B, that is not unlocked pulses bcnt_hi_wr during the write cycle and leaves the configuration unchanged. A write that used the unlock consumes it, so a second write in a row goes to the byte count.
- R5: Any read or write other than a page-0 read of 0x0B clears the unlock. Idle cycles (no strobe) do not clear it.
- R6: coax_en is 0 for media 00 (twisted pair), 1 for media 01 (thin coax) and 0 for media 10 (thick coax). For media 11 (automatic), it equals media_is_coax.
- R7: Bit 2 of the read byte is link_ok. Host writes never change it.
- R8: ready_after_ale equals the stored ready-mode bit: 1 means the hold-off starts after address latch enable rises, 0 means after the command strobe.
- R9: A bus_err_evt pulse sets the bus-error flag (bit 5). The flag holds until a read of page 0, offset 0x0B, returns it, and it is cleared after that read. An event in the same cycle as that read leaves the flag set.
- R10: Bits 3, 6 and 7 read as 0 and ignore writes. A write with bit 5 set does not set the bus-error flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | ADDR_W (4) | Register offset within the page |
| bus_page | input | PAGE_W (2) | Register page select |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| link_ok | input | 1 | Link status from the transceiver |
| media_is_coax | input | 1 | Detected medium needs the coax path (automatic mode) |
| bus_err_evt | input | 1 | Bus-error event pulse from the cycle monitor |
| cfg_rdata | output | 8 | Read data of the configuration byte, zero when not selected |
| bcnt_hi_wr | output | 1 | Write strobe for the aliased byte-count high register |
| coax_en | output | 1 | Coax transceiver enable |
| ready_after_ale | output | 1 | Ready hold-off mode select |

## Verification
Several rules are checked by the assertions on every clock. The byte-count strobe and the configuration load never coincide, and a byte-count write leaves the configuration stable. Any non-unlocking access drops the unlock. The bus-error flag sets on an event and holds until a selected read. The reserved bits and an unselected read bus stay at zero. Other behaviours are shown only by the bench's ordered scenarios: that idle cycles keep the unlock alive, that exactly one write consumes it, that an event racing a clearing read survives, and that automatic media mode tracks the detect input over time.

// File: rtl/cfgalias_pkg.sv
package cfgalias_pkg;

    localparam int DATA_W   = 8;
    localparam int LINK_BIT = 2;
    localparam int ALE_BIT  = 4;
    localparam int BERR_BIT = 5;

    typedef enum logic [1:0] {
        MEDIA_TWISTED = 2'b00,
        MEDIA_THIN    = 2'b01,
        MEDIA_THICK   = 2'b10,
        MEDIA_AUTO    = 2'b11
    } media_e;

    typedef struct packed {
        media_e media;
        logic   ale_mode;
        logic   bus_err;
    } cfg_s;

    typedef struct packed {
        logic rd_hit;
        logic cfg_we;
        logic bcnt_we;
    } acc_s;

    function automatic logic [DATA_W-1:0] pack_status(cfg_s c, logic link);
        logic [DATA_W-1:0] b;
        b           = '0;
        b[1:0]      = c.media;
        b[LINK_BIT] = link;
        b[ALE_BIT]  = c.ale_mode;
        b[BERR_BIT] = c.bus_err;
        return b;
    endfunction

    function automatic logic coax_for(media_e m, logic detected);
        logic r;
        unique case (m)
            MEDIA_THIN:  r = 1'b1;
            MEDIA_AUTO:  r = detected;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/cfgalias_decode.sv
module cfgalias_decode
    import cfgalias_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PAGE_W   = 2,
    parameter int REG_OFF  = 11,
    parameter int REG_PAGE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic [PAGE_W-1:0] page,
    input  logic              rd,
    input  logic              wr,
    output acc_s              acc,
    output logic              unlock_q
);
    localparam logic [ADDR_W-1:0] OFF_V  = ADDR_W'(REG_OFF);
    localparam logic [PAGE_W-1:0] PAGE_V = PAGE_W'(REG_PAGE);

    logic sel;
    assign sel = (addr == OFF_V) && (page == PAGE_V);

    always_comb begin
        acc.rd_hit  = rd && sel;
        acc.cfg_we  = wr && sel && unlock_q;
        acc.bcnt_we = wr && sel && !unlock_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            unlock_q <= 1'b0;
        end else if (rd && sel) begin
            unlock_q <= 1'b1;
        end else if (rd || wr) begin
            unlock_q <= 1'b0;
        end
    end
endmodule

// File: rtl/cfgalias_store.sv
module cfgalias_store
    import cfgalias_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cfg_we,
    input  logic [1:0] wr_media,
    input  logic       wr_ale,
    input  logic       rd_hit,
    input  logic       err_evt,
    output cfg_s       cfg_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
        end else begin
            if (cfg_we) begin
                cfg_q.media    <= media_e'(wr_media);
                cfg_q.ale_mode <= wr_ale;
            end
            if (err_evt) begin
                cfg_q.bus_err <= 1'b1;
            end else if (rd_hit) begin
                cfg_q.bus_err <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/cfgalias_media.sv
module cfgalias_media
    import cfgalias_pkg::*;
(
    input  media_e media,
    input  logic   detected,
    output logic   coax_en
);
    assign coax_en = coax_for(media, detected);
endmodule

// File: rtl/cfgalias_reg.sv
module cfgalias_reg
    import cfgalias_pkg::*;
#(
    parameter int ADDR_W   = 4,
    parameter int PAGE_W   = 2,
    parameter int REG_OFF  = 11,
    parameter int REG_PAGE = 0
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [PAGE_W-1:0] bus_page,
    input  logic              bus_rd,
    input  logic              bus_wr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              link_ok,
    input  logic              media_is_coax,
    input  logic              bus_err_evt,
    output logic [DATA_W-1:0] cfg_rdata,
    output logic              bcnt_hi_wr,
    output logic              coax_en,
    output logic              ready_after_ale
);
    acc_s acc;
    logic unlock_q;
    cfg_s cfg_q;
    logic unused_wdata;

    assign unused_wdata = ^{bus_wdata[7:5], bus_wdata[3:2]};

    cfgalias_decode #(
        .ADDR_W  (ADDR_W),
        .PAGE_W  (PAGE_W),
        .REG_OFF (REG_OFF),
        .REG_PAGE(REG_PAGE)
    ) u_decode (
        .clk     (clk),
        .rst     (rst),
        .addr    (bus_addr),
        .page    (bus_page),
        .rd      (bus_rd),
        .wr      (bus_wr),
        .acc     (acc),
        .unlock_q(unlock_q)
    );

    cfgalias_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg_we  (acc.cfg_we),
        .wr_media(bus_wdata[1:0]),
        .wr_ale  (bus_wdata[ALE_BIT]),
        .rd_hit  (acc.rd_hit),
        .err_evt (bus_err_evt),
        .cfg_q   (cfg_q)
    );

    cfgalias_media u_media (
        .media   (cfg_q.media),
        .detected(media_is_coax),
        .coax_en (coax_en)
    );

    assign cfg_rdata       = acc.rd_hit ? pack_status(cfg_q, link_ok) : '0;
    assign bcnt_hi_wr      = acc.bcnt_we;
    assign ready_after_ale = cfg_q.ale_mode;
endmodule

// File: rtl/cfgalias_chk.sv
module cfgalias_chk
    import cfgalias_pkg::*;
(
    input logic       clk,
    input logic       rst,
    input logic       bus_rd,
    input logic       bus_wr,
    input logic [7:0] bus_wdata,
    input logic       bus_err_evt,
    input logic       link_ok,
    input acc_s       acc,
    input logic       unlock_q,
    input cfg_s       cfg_q,
    input logic [7:0] cfg_rdata,
    input logic       bcnt_hi_wr,
    input logic       coax_en
);
    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (cfg_q == '0 && !unlock_q));

    // R3
    unlocked_load_chk: assert property (@(posedge clk) disable iff (rst)
        acc.cfg_we |=> (cfg_q.media == $past(bus_wdata[1:0]) &&
                        cfg_q.ale_mode == $past(bus_wdata[4])));

    // R4
    alias_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        bcnt_hi_wr |-> !acc.cfg_we);

    // R4
    alias_keeps_cfg_chk: assert property (@(posedge clk) disable iff (rst)
        bcnt_hi_wr |=> $stable({cfg_q.media, cfg_q.ale_mode}));

    // R5
    unlock_drop_chk: assert property (@(posedge clk) disable iff (rst)
        ((bus_rd || bus_wr) && !acc.rd_hit) |=> !unlock_q);

    // R6
    thin_coax_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.media == MEDIA_THIN) |-> coax_en);

    // R6
    twisted_nocoax_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.media == MEDIA_TWISTED || cfg_q.media == MEDIA_THICK) |-> !coax_en);

    // R7
    link_bit_chk: assert property (@(posedge clk) disable iff (rst)
        acc.rd_hit |-> (cfg_rdata[2] == link_ok));

    // R9
    berr_set_chk: assert property (@(posedge clk) disable iff (rst)
        bus_err_evt |=> cfg_q.bus_err);

    // R9
    berr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.bus_err && !acc.rd_hit) |=> cfg_q.bus_err);

    // R2
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !acc.rd_hit |-> (cfg_rdata == 8'h00));

    // R10
    reserved_zero_chk: assert property (@(posedge clk) disable iff (rst)
        acc.rd_hit |-> (cfg_rdata[7:6] == 2'b00 && cfg_rdata[3] == 1'b0));
endmodule

bind cfgalias_reg cfgalias_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_rd     (bus_rd),
    .bus_wr     (bus_wr),
    .bus_wdata  (bus_wdata),
    .bus_err_evt(bus_err_evt),
    .link_ok    (link_ok),
    .acc        (acc),
    .unlock_q   (unlock_q),
    .cfg_q      (cfg_q),
    .cfg_rdata  (cfg_rdata),
    .bcnt_hi_wr (bcnt_hi_wr),
    .coax_en    (coax_en)
);

// File: tb/cfgalias_reg_bench.sv
module cfgalias_reg_bench;
    localparam int T = 20;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = '0;
    logic [1:0] bus_page = '0;
    logic       bus_rd = 1'b0, bus_wr = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic       link_ok = 1'b0, media_is_coax = 1'b0, bus_err_evt = 1'b0;
    logic [7:0] cfg_rdata;
    logic       bcnt_hi_wr, coax_en, ready_after_ale;

    int n_chk = 0, n_bad = 0, cycles = 0;
    bit done = 0;

    logic [1:0] m_media;
    logic       m_ale, m_berr, m_unlock;

    always #(T/2) clk = ~clk;

    cfgalias_reg u_cfgalias_reg (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_page(bus_page),
        .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .link_ok(link_ok), .media_is_coax(media_is_coax), .bus_err_evt(bus_err_evt),
        .cfg_rdata(cfg_rdata), .bcnt_hi_wr(bcnt_hi_wr), .coax_en(coax_en),
        .ready_after_ale(ready_after_ale)
    );

    function automatic logic exp_coax(logic [1:0] m, logic det);
        return (m == 2'b01) ? 1'b1 : (m == 2'b11) ? det : 1'b0;
    endfunction

    function automatic logic [7:0] exp_byte(logic [1:0] m, logic a, logic e, logic l);
        return {2'b00, e, a, 1'b0, l, m};
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic op(logic rd, logic wr, logic [1:0] pg, logic [3:0] ad,
                      logic [7:0] wd, logic evt, string tag);
        logic hit;
        @(negedge clk);
        bus_rd = rd; bus_wr = wr; bus_page = pg; bus_addr = ad;
        bus_wdata = wd; bus_err_evt = evt;
        hit = (pg == 2'd0) && (ad == 4'hB);
        #(T/4);
        check(tag, cfg_rdata, (rd && hit) ? exp_byte(m_media, m_ale, m_berr, link_ok) : 8'h00);
        check("R4 strobe", {7'd0, bcnt_hi_wr}, {7'd0, wr && hit && !m_unlock});
        check("R6 coax", {7'd0, coax_en}, {7'd0, exp_coax(m_media, media_is_coax)});
        check("R8 ready mode", {7'd0, ready_after_ale}, {7'd0, m_ale});
        @(posedge clk);
        if (wr && hit && m_unlock) begin
            m_media = wd[1:0];
            m_ale   = wd[4];
        end
        if (evt) m_berr = 1'b1;
        else if (rd && hit) m_berr = 1'b0;
        if (rd && hit) m_unlock = 1'b1;
        else if (rd || wr) m_unlock = 1'b0;
        #1;
        bus_rd = 0; bus_wr = 0; bus_err_evt = 0;
    endtask

    task automatic rd_cfg(string tag);  op(1, 0, 0, 4'hB, 8'h00, 0, tag); endtask
    task automatic wr_cfg(logic [7:0] d, string tag); op(0, 1, 0, 4'hB, d, 0, tag); endtask
    task automatic idle(string tag); op(0, 0, 0, 4'h0, 8'h00, 0, tag); endtask

    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 100000 && !done) begin
                n_bad++; n_chk++;
                $display("FAIL watchdog actual=%0d expected<=100000 cycles", cycles);
                $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
                $finish;
            end
        end
    end

    initial begin
        int s;
        s = $urandom(32'd4711);
        m_media = 2'b00; m_ale = 0; m_berr = 0; m_unlock = 0;
        link_ok = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 0;

        // R1: reset state seen through a read and the outputs
        check("R1 coax", {7'd0, coax_en}, 8'h00);
        check("R1 ready", {7'd0, ready_after_ale}, 8'h00);
        rd_cfg("R1");

        // R3: read unlocks, write loads thin coax and ALE mode
        wr_cfg(8'h11, "R3 write");
        rd_cfg("R3");
        check("R3 coax", {7'd0, coax_en}, 8'h01);

        // R4: write without read goes to byte count
        op(1, 0, 0, 4'h0, 8'h00, 0, "R4 other read");
        wr_cfg(8'h02, "R4 plain write");
        rd_cfg("R4");
        wr_cfg(8'h02, "R4 unlocked write");
        wr_cfg(8'h13, "R4 second write");
        rd_cfg("R4 after pair");

        // R5: intervening accesses kill unlock, idle does not
        op(1, 0, 0, 4'h5, 8'h00, 0, "R5 other read");
        rd_cfg("R5");
        op(1, 0, 1, 4'hB, 8'h00, 0, "R5 other page");
        wr_cfg(8'h03, "R5 write after page1");
        rd_cfg("R5");
        op(0, 1, 0, 4'h2, 8'h55, 0, "R5 other write");
        wr_cfg(8'h03, "R5 write after other write");
        rd_cfg("R5");
        idle("R5 idle");
        idle("R5 idle");
        wr_cfg(8'h03, "R5 write after idle");
        rd_cfg("R5 idle kept unlock");

        // R6: automatic mode follows detect
        media_is_coax = 1'b1; idle("R6 auto det1");
        media_is_coax = 1'b0; idle("R6 auto det0");
        rd_cfg("R6"); wr_cfg(8'h00, "R6 twisted"); idle("R6 twisted");
        rd_cfg("R6"); wr_cfg(8'h02, "R6 thick"); idle("R6 thick");

        // R7: link bit tracks input and ignores writes
        link_ok = 1'b0; rd_cfg("R7 link down");
        wr_cfg(8'h06, "R7 write bit2"); rd_cfg("R7");
        link_ok = 1'b1; rd_cfg("R7 link up");

        // R9: sticky bus error
        op(0, 0, 0, 4'h0, 8'h00, 1, "R9 event");
        idle("R9 hold");
        rd_cfg("R9 first read");
        rd_cfg("R9 cleared");
        op(0, 0, 0, 4'h0, 8'h00, 1, "R9 event2");
        op(1, 0, 0, 4'hB, 8'h00, 1, "R9 race");
        rd_cfg("R9 survives race");

        // R10: reserved bits and bit 5 ignore writes
        wr_cfg(8'hFF, "R10 write ones");
        rd_cfg("R10");
        check("R10 berr stays clear", {7'd0, m_berr}, 8'h00);

        // R2: constrained random traffic around the shared address
        for (int i = 0; i < 600; i++) begin
            logic [1:0] pg;
            logic [3:0] ad;
            logic [2:0] kind;
            pg = ($urandom % 4 == 0) ? 2'($urandom) : 2'd0;
            ad = ($urandom % 3 == 0) ? 4'($urandom) : 4'hB;
            kind = 3'($urandom);
            link_ok = ($urandom % 8 != 0);
            media_is_coax = 1'($urandom);
            op(kind[0], !kind[0] && kind[1], pg, ad, 8'($urandom),
               ($urandom % 10 == 0), "R2 random");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule